// File: doc/BRIEF.md
# Fine-Grained Multithreaded Issue Controller

This block feeds a deep, fixed-latency arithmetic pipeline from a pool of thread contexts. All threads run the same program in lockstep. For each instruction, the controller issues that instruction once for every active thread, in ascending thread order. It fetches the next instruction only after the whole group has issued. As long as the number of active threads is at least the pipeline depth, a thread's earlier result has already left the pipeline by the time that thread issues again. No hazard check and no stall are needed in that case. With fewer threads, each round is padded with empty slots up to the pipeline depth, so the spacing between a thread's issues never drops below the depth.

Every issue slot is shifted down a delay line that matches the pipeline depth. Each entry carries the thread number, the destination register and a write enable. The write enable is the thread's predicate bit, sampled when the thread issues. A thread whose predicate is false still issues and still retires, but its write enable is low, so the register file keeps its old value. When the last thread's final instruction leaves the delay line, the controller goes idle and raises a completion flag.

A host loads the active thread count and the index of the last instruction, then pulses start. The instruction store is external: the controller presents a fetch index, and the store returns the instruction word and its destination field in the same cycle.

Top module: `mt_issue_ctrl`

## Requirements
- R1: While in reset and afterwards until a start is accepted, `iss_valid_o`, `wb_valid_o`, `wb_en_o`, `busy_o` and `done_o` are all 0.
- R2: A start is accepted only while `busy_o` is 0. A start pulse seen while a run is in progress has no effect on the issue sequence or on completion timing.
- R3: During a run, issue slot k of round r (counting from the first cycle after the accepted start) carries thread number k and fetch index r. `iss_instr_o` equals `instr_i`. Within a round the thread number rises by one each issuing cycle, and the fetch index rises by one at each new round.
- R4: With a thread count N at least the pipeline depth D, a valid issue happens in every cycle of the run with no gaps, N*(L+1) issues in total, where L is the last instruction index.
- R5: With N below D, every round except the last spans D cycles: N issuing cycles followed by D-N empty ones. The last round ends right after thread N-1 issues.
- R6: Every issue reappears on the retire outputs exactly D cycles later, with the same thread number and the destination field that was presented at issue time.
- R7: Predicated threads always issue and always retire. `wb_en_o` equals bit `tid` of `pred_i` as sampled in the issue cycle, and it is never 1 without `wb_valid_o`.
- R8: In the cycle after the final retirement, `busy_o` drops to 0 and `done_o` rises. `done_o` stays 1 until the next accepted start, which clears it.
- R9: A start with a thread count of 0, or above the maximum thread count, is ignored. `busy_o` stays 0 and `done_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run (accepted only when idle) |
| thread_count_i | input | $clog2(MAX_THREADS+1) | Number of active threads, 1..MAX_THREADS |
| last_pc_i | input | PC_W | Index of the final instruction of the program |
| pred_i | input | MAX_THREADS | Per-thread predicate, 1 = commit |
| fetch_pc_o | output | PC_W | Index of the instruction being issued |
| instr_i | input | INSTR_W | Instruction word for `fetch_pc_o` |
| dst_i | input | REG_W | Destination register field for `fetch_pc_o` |
| iss_valid_o | output | 1 | An instruction enters the pipeline this cycle |
| iss_tid_o | output | $clog2(MAX_THREADS) | Thread issuing this cycle |
| iss_instr_o | output | INSTR_W | Instruction issued this cycle |
| wb_valid_o | output | 1 | An issue slot leaves the pipeline |
| wb_en_o | output | 1 | Predicate-qualified register write enable |
| wb_tid_o | output | $clog2(MAX_THREADS) | Thread of the retiring slot |
| wb_dst_o | output | REG_W | Destination register of the retiring slot |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The last run has completed |

## Verification
Two functions can collide in a single cycle. One is retirement of a thread's result. The other is the next issue of that same thread, which happens in the same cycle whenever the thread count equals the pipeline depth, or whenever a round is padded out to the depth. The bench provokes this with runs at N equal to D and at N well below D. In every cycle it compares the issue and retire ports against positions computed from the round/slot formula, so a slot that comes one cycle early or one cycle late fails on both streams. A second overlap, a start pulse arriving mid-run, is judged by requiring the full expected sequence and the original completion cycle to be unchanged.

// File: rtl/mt_issue_pkg.sv
package mt_issue_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_RUN   = 2'd1,
      SEQ_DRAIN = 2'd2
   } seq_state_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mt_issue_delay.sv
module mt_issue_delay #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned W     = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("mt_issue_delay: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] hold_q;
      always_ff @(posedge clk) begin
         if (!rst_n) hold_q <= '0;
         else        hold_q <= d_i;
      end
      assign q_o = hold_q;
   end else begin : g_chain
      logic [W-1:0] stage_q [DEPTH];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int k = 0; k < int'(DEPTH); k++) stage_q[k] <= '0;
         end else begin
            stage_q[0] <= d_i;
            for (int k = 1; k < int'(DEPTH); k++) stage_q[k] <= stage_q[k-1];
         end
      end
      assign q_o = stage_q[DEPTH-1];
   end

endmodule

// File: rtl/mt_issue_seq.sv
module mt_issue_seq
   import mt_issue_pkg::*;
#(
   parameter int unsigned MAX_THREADS = 256,
   parameter int unsigned PIPE_DEPTH  = 64,
   parameter int unsigned PC_W        = 8,
   parameter int unsigned TID_W       = 8,
   parameter int unsigned CNT_W       = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] thread_count_i,
   input  logic [PC_W-1:0]  last_pc_i,
   input  logic             retire_last_i,
   output logic             start_ok_o,
   output logic             issue_o,
   output logic             final_o,
   output logic [TID_W-1:0] tid_o,
   output logic [PC_W-1:0]  pc_o,
   output logic             busy_o
);

   localparam int unsigned SLOT_MAX = max_u(MAX_THREADS, PIPE_DEPTH);
   localparam int unsigned SLOT_W   = max_u($clog2(SLOT_MAX), 1);
   localparam int unsigned CMP_W    = max_u(SLOT_W, CNT_W) + 1;

   seq_state_e       state_q;
   logic [CMP_W-1:0] slot_q, nthr_q, period_q;
   logic [PC_W-1:0]  pc_q, last_q;
   logic [CMP_W-1:0] cnt_ext, period_d;
   logic             round_end;

   assign cnt_ext    = CMP_W'(thread_count_i);
   assign start_ok_o = (state_q == SEQ_IDLE) && start_i &&
                       (cnt_ext != '0) && (cnt_ext <= CMP_W'(MAX_THREADS));

   // Round length: padded up to the pipeline depth when threads are scarce
   if (PIPE_DEPTH <= 1) begin : g_no_pad
      assign period_d = cnt_ext;
   end else begin : g_pad
      assign period_d = (cnt_ext >= CMP_W'(PIPE_DEPTH)) ? cnt_ext : CMP_W'(PIPE_DEPTH);
   end

   assign issue_o   = (state_q == SEQ_RUN) && (slot_q < nthr_q);
   assign final_o   = issue_o && (pc_q == last_q) && (slot_q == nthr_q - 1'b1);
   assign round_end = (slot_q == period_q - 1'b1);
   assign tid_o     = TID_W'(slot_q);
   assign pc_o      = pc_q;
   assign busy_o    = (state_q != SEQ_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         slot_q   <= '0;
         nthr_q   <= '0;
         period_q <= '0;
         pc_q     <= '0;
         last_q   <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start_ok_o) begin
                  state_q  <= SEQ_RUN;
                  slot_q   <= '0;
                  pc_q     <= '0;
                  nthr_q   <= cnt_ext;
                  period_q <= period_d;
                  last_q   <= last_pc_i;
               end
            end
            SEQ_RUN: begin
               if (final_o) begin
                  state_q <= SEQ_DRAIN;
               end else if (round_end) begin
                  slot_q <= '0;
                  pc_q   <= pc_q + 1'b1;
               end else begin
                  slot_q <= slot_q + 1'b1;
               end
            end
            SEQ_DRAIN: begin
               if (retire_last_i) state_q <= SEQ_IDLE;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mt_issue_retire.sv
module mt_issue_retire #(
   parameter int unsigned TID_W = 8,
   parameter int unsigned REG_W = 6,
   parameter int unsigned ENT_W = TID_W + REG_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_ok_i,
   input  logic [ENT_W-1:0] entry_i,
   output logic             wb_valid_o,
   output logic             wb_en_o,
   output logic [TID_W-1:0] wb_tid_o,
   output logic [REG_W-1:0] wb_dst_o,
   output logic             retire_last_o,
   output logic             done_o
);

   logic entry_last;
   logic done_q;

   assign {wb_valid_o, wb_en_o, entry_last, wb_tid_o, wb_dst_o} = entry_i;
   assign retire_last_o = wb_valid_o && entry_last;

   always_ff @(posedge clk) begin
      if (!rst_n)             done_q <= 1'b0;
      else if (start_ok_i)    done_q <= 1'b0;
      else if (retire_last_o) done_q <= 1'b1;
   end

   assign done_o = done_q;

endmodule

// File: rtl/mt_issue_ctrl.sv
module mt_issue_ctrl #(
   parameter int unsigned MAX_THREADS = 256,
   parameter int unsigned PIPE_DEPTH  = 64,
   parameter int unsigned PC_W        = 8,
   parameter int unsigned INSTR_W     = 32,
   parameter int unsigned REG_W       = 6,
   localparam int unsigned TID_W      = $clog2(MAX_THREADS),
   localparam int unsigned CNT_W      = $clog2(MAX_THREADS + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [CNT_W-1:0]       thread_count_i,
   input  logic [PC_W-1:0]        last_pc_i,
   input  logic [MAX_THREADS-1:0] pred_i,
   output logic [PC_W-1:0]        fetch_pc_o,
   input  logic [INSTR_W-1:0]     instr_i,
   input  logic [REG_W-1:0]       dst_i,
   output logic                   iss_valid_o,
   output logic [TID_W-1:0]       iss_tid_o,
   output logic [INSTR_W-1:0]     iss_instr_o,
   output logic                   wb_valid_o,
   output logic                   wb_en_o,
   output logic [TID_W-1:0]       wb_tid_o,
   output logic [REG_W-1:0]       wb_dst_o,
   output logic                   busy_o,
   output logic                   done_o
);

   localparam int unsigned ENT_W = TID_W + REG_W + 3;

   if (MAX_THREADS < 2) begin : g_bad_threads
      $error("mt_issue_ctrl: MAX_THREADS must be at least 2");
   end
   if (PIPE_DEPTH < 1) begin : g_bad_depth
      $error("mt_issue_ctrl: PIPE_DEPTH must be at least 1");
   end
   if (PC_W < 1 || REG_W < 1 || INSTR_W < 1) begin : g_bad_width
      $error("mt_issue_ctrl: field widths must be nonzero");
   end

   logic             start_ok, issue, final_iss, retire_last, wen;
   logic [ENT_W-1:0] ent_in, ent_out;

   mt_issue_seq #(
      .MAX_THREADS(MAX_THREADS),
      .PIPE_DEPTH (PIPE_DEPTH),
      .PC_W       (PC_W),
      .TID_W      (TID_W),
      .CNT_W      (CNT_W)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .thread_count_i(thread_count_i),
      .last_pc_i     (last_pc_i),
      .retire_last_i (retire_last),
      .start_ok_o    (start_ok),
      .issue_o       (issue),
      .final_o       (final_iss),
      .tid_o         (iss_tid_o),
      .pc_o          (fetch_pc_o),
      .busy_o        (busy_o)
   );

   // Predicate is sampled at issue; a false predicate only masks the write
   assign wen         = issue && pred_i[iss_tid_o];
   assign iss_valid_o = issue;
   assign iss_instr_o = instr_i;
   assign ent_in      = {issue, wen, final_iss, iss_tid_o, dst_i};

   mt_issue_delay #(
      .DEPTH(PIPE_DEPTH),
      .W    (ENT_W)
   ) u_delay (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (ent_in),
      .q_o  (ent_out)
   );

   mt_issue_retire #(
      .TID_W(TID_W),
      .REG_W(REG_W),
      .ENT_W(ENT_W)
   ) u_retire (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_ok_i   (start_ok),
      .entry_i      (ent_out),
      .wb_valid_o   (wb_valid_o),
      .wb_en_o      (wb_en_o),
      .wb_tid_o     (wb_tid_o),
      .wb_dst_o     (wb_dst_o),
      .retire_last_o(retire_last),
      .done_o       (done_o)
   );

endmodule

// File: rtl/mt_issue_chk.sv
module mt_issue_chk #(
   parameter int unsigned TID_W = 8,
   parameter int unsigned PC_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             iss_valid,
   input logic [TID_W-1:0] iss_tid,
   input logic [PC_W-1:0]  fetch_pc,
   input logic             wb_valid,
   input logic             wb_en,
   input logic             busy,
   input logic             done
);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !iss_valid);

   a_r3_tid_step: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && $past(iss_valid) && fetch_pc == $past(fetch_pc))
      |-> iss_tid == TID_W'($past(iss_tid) + 1'b1));

   a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && fetch_pc != $past(fetch_pc))
      |-> (fetch_pc == PC_W'($past(fetch_pc) + 1'b1)) && iss_valid && (iss_tid == '0));

   a_r7_wen_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> wb_valid);

   a_r8_done_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(wb_valid) && !busy);

   a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

bind mt_issue_ctrl mt_issue_chk #(
   .TID_W(TID_W),
   .PC_W (PC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .iss_valid(iss_valid_o),
   .iss_tid  (iss_tid_o),
   .fetch_pc (fetch_pc_o),
   .wb_valid (wb_valid_o),
   .wb_en    (wb_en_o),
   .busy     (busy_o),
   .done     (done_o)
);

// File: tb/sim_mt_issue_ctrl.sv
`timescale 1ns/1ps
module sim_mt_issue_ctrl;

   localparam int D   = 8;
   localparam int MT  = 16;
   localparam int PCW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [4:0]    tcount = '0;
   logic [PCW-1:0] last_pc = '0;
   logic [MT-1:0] pred = '0;
   logic [PCW-1:0] fetch_pc;
   logic [31:0]   instr;
   logic [5:0]    dst;
   logic          iss_valid, wb_valid, wb_en, busy, done;
   logic [3:0]    iss_tid, wb_tid;
   logic [31:0]   iss_instr;
   logic [5:0]    wb_dst;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   assign instr = {24'h5A17C3, fetch_pc};
   assign dst   = fetch_pc[5:0] ^ 6'h2A;

   mt_issue_ctrl #(
      .MAX_THREADS(MT),
      .PIPE_DEPTH (D),
      .PC_W       (PCW),
      .INSTR_W    (32),
      .REG_W      (6)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .thread_count_i(tcount),
      .last_pc_i(last_pc), .pred_i(pred), .fetch_pc_o(fetch_pc),
      .instr_i(instr), .dst_i(dst), .iss_valid_o(iss_valid),
      .iss_tid_o(iss_tid), .iss_instr_o(iss_instr), .wb_valid_o(wb_valid),
      .wb_en_o(wb_en), .wb_tid_o(wb_tid), .wb_dst_o(wb_dst),
      .busy_o(busy), .done_o(done)
   );

   task automatic chk(input bit ok, input string msg);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s", msg);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         summary();
      end
   end

   // One complete run; every cycle is compared with the round/slot formula
   task automatic run_case(input string name, input int n, input int last,
                           input logic [MT-1:0] p, input bit poke);
      int per, w;
      per = (n >= D) ? n : D;
      w   = last * per + n;
      @(negedge clk);
      tcount = 5'(n); last_pc = PCW'(last); pred = p; start = 1'b1;
      for (int i = 0; i <= w + D + 1; i++) begin
         bit ev, ewv, ewe;
         int et, ep, j, wt, wp;
         @(negedge clk);
         start = 1'b0;
         if (poke && i == 3) begin
            start = 1'b1; tcount = 5'd2;   // R2: must be ignored mid-run
         end
         ev = (i < w) && ((i % per) < n);
         et = i % per; ep = i / per;
         chk(iss_valid == ev && (!ev || (iss_tid == 4'(et) && fetch_pc == PCW'(ep)
             && iss_instr == {24'h5A17C3, 8'(ep)})),
             $sformatf("R3/R4/R5 %s c%0d issue act v%0d t%0d pc%0d exp v%0d t%0d pc%0d",
                       name, i, iss_valid, iss_tid, fetch_pc, ev, et, ep));
         j = i - D;
         ewv = (j >= 0) && (j < w) && ((j % per) < n);
         wt = (j >= 0) ? j % per : 0; wp = (j >= 0) ? j / per : 0;
         ewe = ewv && p[wt];
         chk(wb_valid == ewv && wb_en == ewe &&
             (!ewv || (wb_tid == 4'(wt) && wb_dst == (6'(wp) ^ 6'h2A))),
             $sformatf("R6/R7 %s c%0d retire act v%0d e%0d t%0d d%0d exp v%0d e%0d t%0d d%0d",
                       name, i, wb_valid, wb_en, wb_tid, wb_dst, ewv, ewe, wt,
                       6'(wp) ^ 6'h2A));
         chk(busy == (i < w + D) && done == (i >= w + D),
             $sformatf("R8/R2 %s c%0d status act busy%0d done%0d exp busy%0d done%0d",
                       name, i, busy, done, i < w + D, i >= w + D));
      end
   endtask

   task automatic reset_case();
      @(negedge clk);
      chk(!iss_valid && !wb_valid && !wb_en && !busy && !done,
          $sformatf("R1 in reset act v%0d w%0d e%0d b%0d d%0d exp all 0",
                    iss_valid, wb_valid, wb_en, busy, done));
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!iss_valid && !wb_valid && !busy && !done,
          $sformatf("R1 after reset act v%0d w%0d b%0d d%0d exp all 0",
                    iss_valid, wb_valid, busy, done));
   endtask

   task automatic bad_start_case(input int n);
      @(negedge clk);
      tcount = 5'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!busy && !iss_valid && done,
          $sformatf("R9 count %0d act busy%0d v%0d done%0d exp busy0 v0 done1",
                    n, busy, iss_valid, done));
      repeat (2) @(negedge clk);
      chk(!busy && !wb_valid,
          $sformatf("R9 count %0d later act busy%0d w%0d exp 0 0", n, busy, wb_valid));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      reset_case();
      run_case("full",   16, 2, 16'hFFFF, 1'b0);   // R4
      run_case("sparse",  3, 2, 16'h0005, 1'b0);   // R5, R7
      run_case("equal",   8, 1, 16'hA5C3, 1'b1);   // R2, R6, same-cycle retire/issue
      run_case("single",  1, 1, 16'h0000, 1'b0);   // R5, R7 all squashed
      bad_start_case(0);                           // R9
      bad_start_case(17);                          // R9
      run_case("odd",    11, 0, 16'h0F0F, 1'b0);   // R4, R8 cleared on start
      finished = 1;
      summary();
   end

endmodule